// File: doc/BRIEF.md
# Pin-Clocked Shift Slice

This block is one 32-bit slice of a parallel pin streamer. It runs on the system clock and samples an external pin clock. Each qualified edge of that pin clock moves a chunk of 1, 2, 4 or 8 bits into the working register. The chunk comes from the data pins, from the slice's own outgoing chunk (a self-loop), or from a neighbouring slice in a chain.

A down-counting position counter counts the shifts. The shift on which the counter sits at zero is the last shift of a word. On that shift the freshly shifted word goes into the shadow register, the old shadow contents go into the working register, and the counter reloads. A one-cycle exchange event then tells a DMA engine or CPU that a full word is waiting.

Words stream out with no back-pressure: the exchange event is a valid strobe with no ready. The consumer must read the shadow register before the next exchange. Simple load ports preset the working register, the shadow register and the counter while the slice is disabled.

Top module: `sgs_slice`

## Requirements
- R1: After reset the working register, the shadow register and the position counter are all zero. The exchange event and the outgoing chunk are low.
- R2: A shift moves the working register right by a width set by `par_mode`: 0 is 1 bit, 1 is 2 bits, 2 is 4 bits, 3 is 8 bits. The low bits of the incoming chunk enter at the top of the register (bit 31 downwards).
- R3: Each shift lowers the position counter by one. A shift made while the counter is zero reloads it from `pos_reload` instead, and that shift ends a word.
- R4: On the shift that ends a word, the shadow register takes the newly shifted word and the working register takes the previous shadow contents.
- R5: `swap_pulse` is high for exactly one clock, in the cycle after the word-ending shift, together with the reloaded counter value.
- R6: A shift needs `qual_in XOR qual_inv` to be 1. Otherwise a pin clock edge leaves every register unchanged.
- R7: With `edge_sel` = 0, a rising edge of `ext_clk` shifts. With `edge_sel` = 1, a falling edge shifts. The other edge does nothing.
- R8: With `cat_en` = 0 the incoming chunk is `pin_in`. With `cat_en` = 1 and `cat_order` = 0 it is the slice's own outgoing chunk, so a preloaded pattern rotates and repeats. With `cat_en` = 1 and any nonzero `cat_order` it is `cat_in`.
- R9: While `enable` is 0, no pin clock edge changes any register.
- R10: `chunk_out` is the low shift-width bits of the working register, zero-extended to 8 bits.
- R11: `ld_work`, `ld_shadow` and `ld_pos` load `ld_data` (the first two) or `pos_reload` (the counter) on the next clock. They take priority over a shift in the same cycle, which is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Slice run enable |
| ext_clk | input | 1 | External pin clock, sampled by clk |
| edge_sel | input | 1 | 0 rising edge, 1 falling edge |
| qual_in | input | 1 | Qualifier from pin |
| qual_inv | input | 1 | Inverts the qualifier |
| par_mode | input | 2 | Shift width code |
| cat_en | input | 1 | 0 pins, 1 concatenated source |
| cat_order | input | 2 | 0 self-loop, nonzero neighbour chain |
| pin_in | input | 8 | Parallel pin data |
| cat_in | input | 8 | Chunk from the neighbouring slice |
| pos_reload | input | 5 | Counter reload value |
| ld_work | input | 1 | Load working register |
| ld_shadow | input | 1 | Load shadow register |
| ld_pos | input | 1 | Load counter from pos_reload |
| ld_data | input | 32 | Load data |
| work_q | output | 32 | Working register |
| shadow_q | output | 32 | Shadow register |
| pos_q | output | 5 | Position counter |
| chunk_out | output | 8 | Outgoing chunk to neighbour or pins |
| swap_pulse | output | 1 | Exchange event (valid strobe) |

## Verification
A vector table runs single shifts in every width mode with data from each source. A pin/neighbour pair with different values shows which source was picked. Asymmetric words make a wrong direction or width show up. A full four-byte word against a distinct shadow value checks the exchange in both directions and its counter timing. A rotate pattern that must come back after a full turn proves the self-loop. Blocked qualifiers, the unused clock edge and a disabled slice must each leave the registers as they were.

// File: rtl/sgs_pkg.sv
package sgs_pkg;
  typedef enum logic [1:0] {
    PM_1B = 2'd0,
    PM_2B = 2'd1,
    PM_4B = 2'd2,
    PM_8B = 2'd3
  } par_mode_e;

  typedef enum logic [1:0] {
    SRC_PINS,
    SRC_LOOP,
    SRC_CHAIN
  } src_sel_e;
endpackage

// File: rtl/sgs_edge_gate.sv
module sgs_edge_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ext_clk,
  input  logic edge_sel,
  input  logic qual_in,
  input  logic qual_inv,
  input  logic hold,
  output logic shift_req
);
  logic ext_prev;
  logic rise, fall, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_prev <= 1'b0;
    else        ext_prev <= ext_clk;
  end

  always_comb begin
    rise      = ext_clk & ~ext_prev;
    fall      = ~ext_clk & ext_prev;
    hit       = edge_sel ? fall : rise;
    shift_req = enable & hit & (qual_in ^ qual_inv) & ~hold;
  end
endmodule

// File: rtl/sgs_src_mux.sv
module sgs_src_mux
  import sgs_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 8,
  localparam int NM = $clog2(CW) + 1,
  localparam int MW = $clog2(NM)
) (
  input  logic [DW-1:0] work,
  input  logic [MW-1:0] mode,
  input  logic          cat_en,
  input  logic [1:0]    cat_order,
  input  logic [CW-1:0] pin_in,
  input  logic [CW-1:0] cat_in,
  output logic [DW-1:0] shifted,
  output logic [CW-1:0] chunk_out
);
  src_sel_e             src;
  logic [CW-1:0]        in_chunk;
  logic [NM-1:0][DW-1:0] cand;
  logic [NM-1:0][CW-1:0] outc;

  always_comb begin
    if (!cat_en)                src = SRC_PINS;
    else if (cat_order == 2'd0) src = SRC_LOOP;
    else                        src = SRC_CHAIN;
    case (src)
      SRC_LOOP:  in_chunk = chunk_out;
      SRC_CHAIN: in_chunk = cat_in;
      default:   in_chunk = pin_in;
    endcase
  end

  for (genvar m = 0; m < NM; m++) begin : g_mode
    localparam int W = 1 << m;
    localparam logic [CW-1:0] MASK = CW'((1 << W) - 1);
    assign cand[m] = {in_chunk[W-1:0], work[DW-1:W]};
    assign outc[m] = work[CW-1:0] & MASK;
  end

  always_comb begin
    shifted   = cand[mode];
    chunk_out = outc[mode];
  end
endmodule

// File: rtl/sgs_pos_ctr.sv
module sgs_pos_ctr #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift,
  input  logic          load,
  input  logic [PW-1:0] reload,
  output logic [PW-1:0] pos,
  output logic          expire
);
  assign expire = shift && (pos == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos <= '0;
    else if (load)   pos <= reload;
    else if (expire) pos <= reload;
    else if (shift)  pos <= pos - 1'b1;
  end
endmodule

// File: rtl/sgs_slice.sv
module sgs_slice #(
  parameter int DW = 32,
  parameter int CW = 8,
  localparam int PW = $clog2(DW),
  localparam int MW = $clog2($clog2(CW) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          ext_clk,
  input  logic          edge_sel,
  input  logic          qual_in,
  input  logic          qual_inv,
  input  logic [MW-1:0] par_mode,
  input  logic          cat_en,
  input  logic [1:0]    cat_order,
  input  logic [CW-1:0] pin_in,
  input  logic [CW-1:0] cat_in,
  input  logic [PW-1:0] pos_reload,
  input  logic          ld_work,
  input  logic          ld_shadow,
  input  logic          ld_pos,
  input  logic [DW-1:0] ld_data,
  output logic [DW-1:0] work_q,
  output logic [DW-1:0] shadow_q,
  output logic [PW-1:0] pos_q,
  output logic [CW-1:0] chunk_out,
  output logic          swap_pulse
);
  logic          any_load;
  logic          shift;
  logic          expire;
  logic [DW-1:0] shifted;

  assign any_load = ld_work | ld_shadow | ld_pos;

  sgs_edge_gate u_gate (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ext_clk(ext_clk),
    .edge_sel(edge_sel), .qual_in(qual_in), .qual_inv(qual_inv),
    .hold(any_load), .shift_req(shift)
  );

  sgs_src_mux #(.DW(DW), .CW(CW)) u_mux (
    .work(work_q), .mode(par_mode), .cat_en(cat_en), .cat_order(cat_order),
    .pin_in(pin_in), .cat_in(cat_in), .shifted(shifted), .chunk_out(chunk_out)
  );

  sgs_pos_ctr #(.PW(PW)) u_pos (
    .clk(clk), .rst_n(rst_n), .shift(shift), .load(ld_pos),
    .reload(pos_reload), .pos(pos_q), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q     <= '0;
      shadow_q   <= '0;
      swap_pulse <= 1'b0;
    end else begin
      swap_pulse <= expire;
      if (ld_work)     work_q <= ld_data;
      else if (expire) work_q <= shadow_q;
      else if (shift)  work_q <= shifted;
      if (ld_shadow)   shadow_q <= ld_data;
      else if (expire) shadow_q <= shifted;
    end
  end
endmodule

// File: rtl/sgs_slice_chk.sv
module sgs_slice_chk #(
  parameter int DW = 32,
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          qual_in,
  input logic          qual_inv,
  input logic          ld_work,
  input logic          ld_shadow,
  input logic          ld_pos,
  input logic [PW-1:0] pos_reload,
  input logic [DW-1:0] work_q,
  input logic [DW-1:0] shadow_q,
  input logic [PW-1:0] pos_q,
  input logic          swap_pulse
);
  logic quiet;
  assign quiet = !ld_work && !ld_shadow && !ld_pos;

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    swap_pulse |=> !swap_pulse);

  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(swap_pulse) |-> pos_q == $past(pos_reload));

  a_r4_exchange: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(swap_pulse) |-> work_q == $past(shadow_q));

  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && quiet) |=> ($stable(work_q) && $stable(shadow_q) && $stable(pos_q) && !swap_pulse));

  a_r6_qual_block: assert property (@(posedge clk) disable iff (!rst_n)
    (!(qual_in ^ qual_inv) && quiet) |=> ($stable(work_q) && $stable(pos_q)));
endmodule

bind sgs_slice sgs_slice_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .qual_in(qual_in),
  .qual_inv(qual_inv), .ld_work(ld_work), .ld_shadow(ld_shadow),
  .ld_pos(ld_pos), .pos_reload(pos_reload), .work_q(work_q),
  .shadow_q(shadow_q), .pos_q(pos_q), .swap_pulse(swap_pulse)
);

// File: tb/sgs_slice_tb.sv
module sgs_slice_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, ext_clk = 1'b0, edge_sel = 1'b0;
  logic qual_in = 1'b1, qual_inv = 1'b0;
  logic [1:0] par_mode = 2'd3, cat_order = 2'd0;
  logic cat_en = 1'b0;
  logic [7:0] pin_in = '0, cat_in = '0;
  logic [4:0] pos_reload = 5'd31;
  logic ld_work = 0, ld_shadow = 0, ld_pos = 0;
  logic [31:0] ld_data = '0;
  logic [31:0] work_q, shadow_q;
  logic [4:0] pos_q;
  logic [7:0] chunk_out;
  logic swap_pulse;
  int n_run = 0, n_fail = 0;
  logic seen;

  always #2.5 clk = ~clk;

  sgs_slice dut_i (.*);

  typedef struct packed {
    logic [1:0]  mode;
    logic        cen;
    logic [1:0]  ord;
    logic [7:0]  pin;
    logic [7:0]  cat;
    logic [31:0] init;
    logic [31:0] exp;
    logic [7:0]  chk;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 1'b0, 2'd0, 8'h01, 8'h00, 32'h00000000, 32'h80000000, 8'h00},
    '{2'd3, 1'b0, 2'd0, 8'hA5, 8'h00, 32'h12345678, 32'hA5123456, 8'h78},
    '{2'd1, 1'b0, 2'd0, 8'h02, 8'h00, 32'h0000000F, 32'h80000003, 8'h03},
    '{2'd2, 1'b0, 2'd0, 8'h0C, 8'h00, 32'hFFFF0000, 32'hCFFFF000, 8'h00},
    '{2'd3, 1'b1, 2'd0, 8'hFF, 8'hFF, 32'h12345678, 32'h78123456, 8'h78},
    '{2'd0, 1'b1, 2'd0, 8'h00, 8'h00, 32'h00000001, 32'h80000000, 8'h01},
    '{2'd3, 1'b1, 2'd3, 8'hFF, 8'h3C, 32'h00000000, 32'h3C000000, 8'h00},
    '{2'd3, 1'b0, 2'd0, 8'h22, 8'h11, 32'hFFFFFFFF, 32'h22FFFFFF, 8'hFF}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tog();
    @(negedge clk) ext_clk = ~ext_clk;
    @(negedge clk);
  endtask

  // one full pin clock period: rising edge first; records the exchange event
  task automatic shift_once();
    tog();
    seen = swap_pulse;
    tog();
  endtask

  task automatic load(input logic w, input logic s, input logic p, input logic [31:0] d);
    @(negedge clk);
    ld_work = w; ld_shadow = s; ld_pos = p; ld_data = d;
    @(negedge clk);
    ld_work = 0; ld_shadow = 0; ld_pos = 0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 work", work_q, 0);
    chk("R1 shadow", shadow_q, 0);
    chk("R1 pos", {27'd0, pos_q}, 0);
    chk("R1 pulse/chunk", {23'd0, swap_pulse, chunk_out}, 0);
    rst_n = 1'b1;

    // table: R2 widths, R8 sources, R10 outgoing chunk
    for (int i = 0; i < 8; i++) begin
      enable = 0;
      par_mode = VEC[i].mode; cat_en = VEC[i].cen; cat_order = VEC[i].ord;
      pin_in = VEC[i].pin; cat_in = VEC[i].cat; pos_reload = 5'd31;
      load(1, 0, 1, VEC[i].init);
      chk("R10 chunk_out", {24'd0, chunk_out}, {24'd0, VEC[i].chk});
      enable = 1;
      shift_once();
      chk("R2/R8 shifted word", work_q, VEC[i].exp);
    end

    // R3/R4/R5 full word exchange in byte mode
    enable = 0; par_mode = 2'd3; cat_en = 0; pos_reload = 5'd3;
    load(1, 1, 1, 32'h0);
    load(0, 1, 0, 32'hDEADBEEF);
    enable = 1;
    pin_in = 8'h11; shift_once();
    chk("R3 pos after one shift", {27'd0, pos_q}, 2);
    chk("R5 no early pulse", {31'd0, seen}, 0);
    pin_in = 8'h22; shift_once();
    pin_in = 8'h33; shift_once();
    chk("R2 three bytes", work_q, 32'h33221100);
    pin_in = 8'h44; shift_once();
    chk("R5 pulse on word end", {31'd0, seen}, 1);
    chk("R5 pulse one cycle", {31'd0, swap_pulse}, 0);
    chk("R4 shadow gets word", shadow_q, 32'h44332211);
    chk("R4 work gets old shadow", work_q, 32'hDEADBEEF);
    chk("R3 reload", {27'd0, pos_q}, 3);

    // R6 qualifier
    pos_reload = 5'd31;
    enable = 0; load(1, 0, 1, 32'h0); enable = 1;
    pin_in = 8'hAB; qual_in = 0;
    shift_once();
    chk("R6 blocked qualifier", work_q, 0);
    qual_inv = 1;
    shift_once();
    chk("R6 inverted qualifier", work_q, 32'hAB000000);
    qual_in = 1; qual_inv = 0;

    // R7 falling edge select
    edge_sel = 1; pin_in = 8'hCD;
    tog();
    chk("R7 rising ignored", work_q, 32'hAB000000);
    tog();
    chk("R7 falling shifts", work_q, 32'hCDAB0000);
    edge_sel = 0;

    // R9 disabled slice
    enable = 0; pin_in = 8'hEE;
    shift_once();
    chk("R9 disabled no shift", work_q, 32'hCDAB0000);
    chk("R9 disabled pos", {27'd0, pos_q}, 29);

    // R8 self-loop repeats after a full turn
    load(1, 0, 1, 32'h000000A5);
    enable = 1; cat_en = 1; cat_order = 0;
    for (int k = 0; k < 4; k++) shift_once();
    chk("R8 loop pattern repeats", work_q, 32'h000000A5);

    // R11 load wins over a same-cycle shift
    cat_en = 0; pin_in = 8'h55;
    @(negedge clk) ext_clk = 1; ld_work = 1; ld_data = 32'h0F0F0F0F;
    @(negedge clk) ld_work = 0;
    chk("R11 load priority", work_q, 32'h0F0F0F0F);
    @(negedge clk) ext_clk = 0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule